// File: doc/BRIEF.md
# Four-Channel DMA Control and Status Register Front End

This block is the register slave of a four-channel DMA controller. A processor reaches it over a simple peripheral bus with a setup phase and an access phase. The block splits a flat 64-byte window into four identical 16-byte channel sets. Each set holds a source address, a destination address, a transfer-cycle count and a control word. The block drives every channel's programmed configuration to a separate channel engine. It takes back two kinds of input from that engine: one-cycle pulses that raise the completion and error flags, and the live count of cycles still to be done.

Software clears a status flag by writing the control word back with that flag at 0. Writing a 1 to a flag leaves it unchanged, so a read-modify-write cannot raise it. When a channel is enabled, the cycle-count register returns the engine's live remaining count instead of the programmed value. A single level interrupt output gathers the enabled flags of all channels. The block has no data path. Writes take effect at the clock edge that closes the access phase. Read data is combinational during the access phase, and every access completes in that phase without wait states.

Top module: `dma_csr_frontend`

## Requirements
- R1: Channel n occupies byte offsets 16·n to 16·n+15. Within a channel, offset 0 is the source address, offset 4 the destination address, offset 8 the cycle count and offset 12 the control word. The address registers hold 32 bits. The cycle count holds 24 bits and reads its upper 8 bits as zero.
- R2: Control bit positions are: 0 enable, 1 completion flag, 2 completion interrupt enable, 3 burst, 4 error flag, 5 error interrupt enable, 6 source bus select, 7 destination bus select (0 peripheral bus, 1 system bus). The remaining fields are: 10:8 source step code, 14:12 destination step code, 19:16 destination request line, 21:20 data width and 27:24 source request line. All other bits read as zero, so writing 0xFFFFFFFE reads back 0x0F3F77EC.
- R3: A software write to the control word never sets bit 1 or bit 4. Writing 0 to one of these bits clears it, and writing 1 leaves it unchanged.
- R4: A one-cycle pulse on eng_done_set[n] or eng_err_set[n] sets channel n's bit 1 or bit 4 at the next clock edge. A pulse wins over a software clear made in the same cycle.
- R5: irq is high exactly when some channel has (bit 1 AND bit 2) or (bit 4 AND bit 5) set in its control word.
- R6: While control bit 0 of a channel is 1, reading its cycle-count offset returns that channel's slice of eng_live_cnt. Otherwise the read returns the programmed count. The programmed value on ch_cnt is not altered by the live count.
- R7: Reset makes every register zero and drives irq low.
- R8: An offset at or above 64, or one whose two low bits are not zero, reads as zero, and a write to it changes no register.
- R9: ch_src, ch_dst, ch_cnt and ch_ctrl present each channel's current register contents, with channel n in slice n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 8 | Byte offset in the window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in access phase |
| eng_done_set | input | 4 | Completion flag set pulses, one per channel |
| eng_err_set | input | 4 | Error flag set pulses, one per channel |
| eng_live_cnt | input | 96 | Live remaining cycles, 24 bits per channel |
| ch_src | output | 128 | Source address per channel |
| ch_dst | output | 128 | Destination address per channel |
| ch_cnt | output | 96 | Programmed cycle count per channel |
| ch_ctrl | output | 128 | Control word per channel |
| irq | output | 1 | Combined interrupt |

## Verification
Distinct data patterns are written to all four register types across all four channels. This separates decode faults, such as one channel aliasing another, from per-field masking faults such as a wrong count width or reserved bits. Writing all-ones to the control word tells the writable fields apart from the flags. Three control-flag patterns are used: flags written as 1, flags written as 0, and a clear that lands in the same cycle as a set pulse. Together they separate "keep", "clear" and "pulse wins". Cycle-count reads with the enable bit off and on distinguish the programmed value from the live count, and flag/enable combinations with one side missing show that the interrupt needs both.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;

  localparam int REG_W = 32;

  // control word bit positions
  localparam int CTL_EN      = 0;
  localparam int CTL_DONE    = 1;
  localparam int CTL_DONE_IE = 2;
  localparam int CTL_BURST   = 3;
  localparam int CTL_ERR     = 4;
  localparam int CTL_ERR_IE  = 5;
  localparam int CTL_SRC_BUS = 6;
  localparam int CTL_DST_BUS = 7;

  // multi-bit fields: lsb and width
  localparam int F_SSTEP_LSB = 8;   localparam int F_SSTEP_W = 3;
  localparam int F_DSTEP_LSB = 12;  localparam int F_DSTEP_W = 3;
  localparam int F_DREQ_LSB  = 16;  localparam int F_DREQ_W  = 4;
  localparam int F_WIDTH_LSB = 20;  localparam int F_WIDTH_W = 2;
  localparam int F_SREQ_LSB  = 24;  localparam int F_SREQ_W  = 4;

  typedef enum logic [1:0] {
    SEL_SRC = 2'd0,
    SEL_DST = 2'd1,
    SEL_CNT = 2'd2,
    SEL_CTL = 2'd3
  } reg_sel_e;

  function automatic logic [REG_W-1:0] field_mask(int lsb, int width);
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < width; i++) m[lsb+i] = 1'b1;
    return m;
  endfunction

  // flags: written only through the clear rule
  localparam logic [REG_W-1:0] CTL_FLAG_MASK =
    field_mask(CTL_DONE, 1) | field_mask(CTL_ERR, 1);

  // plainly writable control bits
  localparam logic [REG_W-1:0] CTL_RW_MASK =
    field_mask(CTL_EN, 1) | field_mask(CTL_DONE_IE, 1) |
    field_mask(CTL_BURST, 1) | field_mask(CTL_ERR_IE, 1) |
    field_mask(CTL_SRC_BUS, 1) | field_mask(CTL_DST_BUS, 1) |
    field_mask(F_SSTEP_LSB, F_SSTEP_W) | field_mask(F_DSTEP_LSB, F_DSTEP_W) |
    field_mask(F_DREQ_LSB, F_DREQ_W) | field_mask(F_WIDTH_LSB, F_WIDTH_W) |
    field_mask(F_SREQ_LSB, F_SREQ_W);

endpackage

// File: rtl/dma_csr_decode.sv
module dma_csr_decode
  import dma_csr_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int ADDR_W   = 8,
  parameter int CH_IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                psel,
  input  logic                penable,
  input  logic                pwrite,
  input  logic [ADDR_W-1:0]   paddr,
  output logic [NUM_CH-1:0]   wr_ch,
  output logic                rd_hit,
  output logic [CH_IDX_W-1:0] ch_idx,
  output reg_sel_e            sel
);
  localparam int WIN_BYTES = NUM_CH * 16;
  localparam logic [ADDR_W:0] WIN_END = (ADDR_W+1)'(WIN_BYTES);

  logic in_win;
  logic wr_go;

  assign in_win = ({1'b0, paddr} < WIN_END) && (paddr[1:0] == 2'b00);
  assign ch_idx = paddr[4 +: CH_IDX_W];
  assign sel    = reg_sel_e'(paddr[3:2]);
  assign wr_go  = psel && penable && pwrite && in_win;
  assign rd_hit = psel && !pwrite && in_win;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_wr
    assign wr_ch[g] = wr_go && (ch_idx == CH_IDX_W'(g));
  end
endmodule

// File: rtl/dma_csr_chan.sv
module dma_csr_chan
  import dma_csr_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  reg_sel_e          sel,
  input  logic [REG_W-1:0]  wdata,
  input  logic              done_set,
  input  logic              err_set,
  output logic [REG_W-1:0]  src_q,
  output logic [REG_W-1:0]  dst_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [REG_W-1:0]  ctl_q
);
  logic [REG_W-1:0] ctl_d;

  always_comb begin
    ctl_d = ctl_q;
    if (wr_en && sel == SEL_CTL)
      ctl_d = (wdata & CTL_RW_MASK) | (ctl_q & wdata & CTL_FLAG_MASK);
    // engine pulses dominate a same-cycle software clear
    if (done_set) ctl_d[CTL_DONE] = 1'b1;
    if (err_set)  ctl_d[CTL_ERR]  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      dst_q <= '0;
      cnt_q <= '0;
      ctl_q <= '0;
    end else begin
      if (wr_en && sel == SEL_SRC) src_q <= wdata;
      if (wr_en && sel == SEL_DST) dst_q <= wdata;
      if (wr_en && sel == SEL_CNT) cnt_q <= wdata[CNT_W-1:0];
      ctl_q <= ctl_d;
    end
  end
endmodule

// File: rtl/dma_csr_irq.sv
module dma_csr_irq
  import dma_csr_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic [NUM_CH*REG_W-1:0] ctl_flat,
  output logic                    irq
);
  logic [NUM_CH-1:0] req;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_req
    logic [REG_W-1:0] c;
    assign c = ctl_flat[g*REG_W +: REG_W];
    assign req[g] = (c[CTL_DONE] & c[CTL_DONE_IE]) | (c[CTL_ERR] & c[CTL_ERR_IE]);
  end

  assign irq = |req;
endmodule

// File: rtl/dma_csr_frontend.sv
module dma_csr_frontend
  import dma_csr_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 24
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     psel,
  input  logic                     penable,
  input  logic                     pwrite,
  input  logic [ADDR_W-1:0]        paddr,
  input  logic [REG_W-1:0]         pwdata,
  output logic [REG_W-1:0]         prdata,
  input  logic [NUM_CH-1:0]        eng_done_set,
  input  logic [NUM_CH-1:0]        eng_err_set,
  input  logic [NUM_CH*CNT_W-1:0]  eng_live_cnt,
  output logic [NUM_CH*REG_W-1:0]  ch_src,
  output logic [NUM_CH*REG_W-1:0]  ch_dst,
  output logic [NUM_CH*CNT_W-1:0]  ch_cnt,
  output logic [NUM_CH*REG_W-1:0]  ch_ctrl,
  output logic                     irq
);
  localparam int CH_IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [NUM_CH-1:0]   wr_ch;
  logic                rd_hit;
  logic [CH_IDX_W-1:0] ch_idx;
  reg_sel_e            sel;

  logic [REG_W-1:0] src_a  [NUM_CH];
  logic [REG_W-1:0] dst_a  [NUM_CH];
  logic [CNT_W-1:0] cnt_a  [NUM_CH];
  logic [REG_W-1:0] ctl_a  [NUM_CH];
  logic [CNT_W-1:0] live_a [NUM_CH];

  dma_csr_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .CH_IDX_W(CH_IDX_W)) u_dec (
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .wr_ch   (wr_ch),
    .rd_hit  (rd_hit),
    .ch_idx  (ch_idx),
    .sel     (sel)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    dma_csr_chan #(.CNT_W(CNT_W)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_ch[g]),
      .sel      (sel),
      .wdata    (pwdata),
      .done_set (eng_done_set[g]),
      .err_set  (eng_err_set[g]),
      .src_q    (src_a[g]),
      .dst_q    (dst_a[g]),
      .cnt_q    (cnt_a[g]),
      .ctl_q    (ctl_a[g])
    );
    assign ch_src [g*REG_W +: REG_W] = src_a[g];
    assign ch_dst [g*REG_W +: REG_W] = dst_a[g];
    assign ch_cnt [g*CNT_W +: CNT_W] = cnt_a[g];
    assign ch_ctrl[g*REG_W +: REG_W] = ctl_a[g];
    assign live_a[g] = eng_live_cnt[g*CNT_W +: CNT_W];
  end

  dma_csr_irq #(.NUM_CH(NUM_CH)) u_irq (
    .ctl_flat (ch_ctrl),
    .irq      (irq)
  );

  // read mux: count offset shows live progress while the channel runs
  always_comb begin
    prdata = '0;
    if (rd_hit) begin
      unique case (sel)
        SEL_SRC: prdata = src_a[ch_idx];
        SEL_DST: prdata = dst_a[ch_idx];
        SEL_CNT: prdata = {{(REG_W-CNT_W){1'b0}},
                           ctl_a[ch_idx][CTL_EN] ? live_a[ch_idx] : cnt_a[ch_idx]};
        SEL_CTL: prdata = ctl_a[ch_idx];
        default: prdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/dma_csr_frontend_chk.sv
module dma_csr_frontend_chk
  import dma_csr_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 24
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    psel,
  input logic                    penable,
  input logic                    pwrite,
  input logic [ADDR_W-1:0]       paddr,
  input logic [REG_W-1:0]        pwdata,
  input logic [REG_W-1:0]        prdata,
  input logic [NUM_CH-1:0]       eng_done_set,
  input logic [NUM_CH-1:0]       eng_err_set,
  input logic [NUM_CH*CNT_W-1:0] eng_live_cnt,
  input logic [NUM_CH*REG_W-1:0] ch_src,
  input logic [NUM_CH*REG_W-1:0] ch_dst,
  input logic [NUM_CH*CNT_W-1:0] ch_cnt,
  input logic [NUM_CH*REG_W-1:0] ch_ctrl,
  input logic                    irq
);
  localparam int WIN_BYTES = NUM_CH * 16;

  logic wr_any;
  logic undef_addr;
  logic exp_irq;

  assign wr_any     = psel && penable && pwrite;
  assign undef_addr = (int'(paddr) >= WIN_BYTES) || (paddr[1:0] != 2'b00);

  always_comb begin
    exp_irq = 1'b0;
    for (int i = 0; i < NUM_CH; i++)
      exp_irq = exp_irq |
        (ch_ctrl[i*REG_W+CTL_DONE] & ch_ctrl[i*REG_W+CTL_DONE_IE]) |
        (ch_ctrl[i*REG_W+CTL_ERR]  & ch_ctrl[i*REG_W+CTL_ERR_IE]);
  end

  p_irq_rule_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq == exp_irq);

  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_ctrl[REG_W-1:0] & ~(CTL_RW_MASK | CTL_FLAG_MASK)) == '0);

  p_undef_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_any && undef_addr && eng_done_set == '0 && eng_err_set == '0) |=>
      ($stable(ch_src) && $stable(ch_dst) && $stable(ch_cnt) && $stable(ch_ctrl)));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic ctl_wr;
    logic cnt_rd;
    assign ctl_wr = wr_any && (int'(paddr) == g*16 + 12);
    assign cnt_rd = psel && penable && !pwrite && (int'(paddr) == g*16 + 8);

    p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
      eng_done_set[g] |=> ch_ctrl[g*REG_W+CTL_DONE]);

    p_err_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      eng_err_set[g] |=> ch_ctrl[g*REG_W+CTL_ERR]);

    p_sw_no_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && !ch_ctrl[g*REG_W+CTL_DONE] && !eng_done_set[g]) |=>
        !ch_ctrl[g*REG_W+CTL_DONE]);

    p_live_cnt_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_rd && ch_ctrl[g*REG_W+CTL_EN]) |->
        prdata == {{(REG_W-CNT_W){1'b0}}, eng_live_cnt[g*CNT_W +: CNT_W]});
  end
endmodule

bind dma_csr_frontend dma_csr_frontend_chk #(
  .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .psel         (psel),
  .penable      (penable),
  .pwrite       (pwrite),
  .paddr        (paddr),
  .pwdata       (pwdata),
  .prdata       (prdata),
  .eng_done_set (eng_done_set),
  .eng_err_set  (eng_err_set),
  .eng_live_cnt (eng_live_cnt),
  .ch_src       (ch_src),
  .ch_dst       (ch_dst),
  .ch_cnt       (ch_cnt),
  .ch_ctrl      (ch_ctrl),
  .irq          (irq)
);

// File: tb/tb_dma_csr_frontend.sv
module tb_dma_csr_frontend;
  localparam int NCH = 4;
  localparam int CW  = 24;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]        paddr = '0;
  logic [31:0]       pwdata = '0;
  logic [31:0]       prdata;
  logic [NCH-1:0]    eng_done_set = '0, eng_err_set = '0;
  logic [NCH*CW-1:0] eng_live_cnt = '0;
  logic [NCH*32-1:0] ch_src, ch_dst, ch_ctrl;
  logic [NCH*CW-1:0] ch_cnt;
  logic              irq;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  dma_csr_frontend dut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .eng_done_set(eng_done_set), .eng_err_set(eng_err_set),
    .eng_live_cnt(eng_live_cnt), .ch_src(ch_src), .ch_dst(ch_dst),
    .ch_cnt(ch_cnt), .ch_ctrl(ch_ctrl), .irq(irq)
  );

  // {offset, write data, expected read-back}
  localparam logic [95:0] VEC [12] = '{
    {32'h00, 32'h11223344, 32'h11223344},  // R1 ch0 source
    {32'h14, 32'hA5A55A5A, 32'hA5A55A5A},  // R1 ch1 destination
    {32'h28, 32'hFFFFFFFF, 32'h00FFFFFF},  // R1 ch2 count, 24 bits
    {32'h3C, 32'hFFFFFFFE, 32'h0F3F77EC},  // R2 R3 ch3 control mask
    {32'h30, 32'hDEADBEEF, 32'hDEADBEEF},  // R1 ch3 source
    {32'h24, 32'h0BADF00D, 32'h0BADF00D},  // R1 ch2 destination
    {32'h18, 32'h12345678, 32'h00345678},  // R1 ch1 count
    {32'h0C, 32'h000000EC, 32'h000000EC},  // R2 ch0 control
    {32'h40, 32'hFFFFFFFF, 32'h00000000},  // R8 beyond window
    {32'h02, 32'hFFFFFFFF, 32'h00000000},  // R8 unaligned
    {32'h08, 32'h00000010, 32'h00000010},  // R1 ch0 count
    {32'h1C, 32'h00000044, 32'h00000044}   // R2 ch1 control
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic apb_wr_pulse(input logic [7:0] a, input logic [31:0] d,
                              input logic [NCH-1:0] dmask);
    @(negedge clk); psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
    @(negedge clk); penable = 1'b1; eng_done_set = dmask;
    @(negedge clk); psel = 1'b0; penable = 1'b0; pwrite = 1'b0; eng_done_set = '0;
  endtask

  task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
    apb_wr_pulse(a, d, '0);
  endtask

  task automatic apb_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
    @(negedge clk); penable = 1'b1;
    #2 d = prdata;
    @(negedge clk); psel = 1'b0; penable = 1'b0;
  endtask

  task automatic pulse(input logic [NCH-1:0] dm, input logic [NCH-1:0] em);
    @(negedge clk); eng_done_set = dm; eng_err_set = em;
    @(negedge clk); eng_done_set = '0; eng_err_set = '0;
  endtask

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R7: every register zero after reset
    for (int a = 0; a < 64; a += 4) begin
      apb_rd(8'(a), rd);
      check("R7 reset read", rd, 32'h0);
    end
    check("R7 reset irq", {31'b0, irq}, 32'h0);

    // table walk: write then read back
    for (int i = 0; i < 12; i++) begin
      apb_wr(VEC[i][71:64], VEC[i][63:32]);
      apb_rd(VEC[i][71:64], rd);
      check($sformatf("R1/R2/R8 vector %0d", i), rd, VEC[i][31:0]);
    end

    check("R5 no flags irq", {31'b0, irq}, 32'h0);
    apb_rd(8'h00, rd);
    check("R8 unaligned write ignored", rd, 32'h11223344);
    check("R9 ch3 src port", ch_src[127:96], 32'hDEADBEEF);
    check("R9 ch2 cnt port", {8'h0, ch_cnt[71:48]}, 32'h00FFFFFF);
    check("R9 ch1 ctrl port", ch_ctrl[63:32], 32'h00000044);

    // R4 / R5: completion pulse on ch1
    pulse(4'b0010, 4'b0000);
    apb_rd(8'h1C, rd);
    check("R4 done pulse sets flag", rd, 32'h46);
    check("R5 irq on done", {31'b0, irq}, 32'h1);

    // R3: write 1 keeps, write 0 clears
    apb_wr(8'h1C, 32'h46);
    apb_rd(8'h1C, rd);
    check("R3 write one keeps", rd, 32'h46);
    apb_wr(8'h1C, 32'h44);
    apb_rd(8'h1C, rd);
    check("R3 write zero clears", rd, 32'h44);
    check("R5 irq after clear", {31'b0, irq}, 32'h0);

    // R4: pulse wins over same-cycle clear
    apb_wr_pulse(8'h1C, 32'h44, 4'b0010);
    apb_rd(8'h1C, rd);
    check("R4 pulse beats clear", rd, 32'h46);
    apb_wr(8'h1C, 32'h44);

    // R5: error flag masked, then enabled, then cleared
    pulse(4'b0000, 4'b0100);
    apb_rd(8'h2C, rd);
    check("R4 err pulse sets flag", rd, 32'h10);
    check("R5 masked err irq", {31'b0, irq}, 32'h0);
    apb_wr(8'h2C, 32'h30);
    check("R5 enabled err irq", {31'b0, irq}, 32'h1);
    apb_wr(8'h2C, 32'h20);
    apb_rd(8'h2C, rd);
    check("R3 err clear", rd, 32'h20);
    check("R5 irq after err clear", {31'b0, irq}, 32'h0);

    // R6: live count while enabled
    eng_live_cnt[23:0] = 24'hABCDEF;
    apb_wr(8'h0C, 32'hED);
    apb_rd(8'h08, rd);
    check("R6 live count read", rd, 32'h00ABCDEF);
    check("R6 programmed port unchanged", {8'h0, ch_cnt[23:0]}, 32'h10);
    apb_wr(8'h0C, 32'hEC);
    apb_rd(8'h08, rd);
    check("R6 programmed count when idle", rd, 32'h10);

    // R7: mid-run reset
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    apb_rd(8'h3C, rd);
    check("R7 ctrl after reset", rd, 32'h0);
    check("R7 src port after reset", ch_src[127:96], 32'h0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: got=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule